// File: doc/BRIEF.md
# Prescaled Watchdog Down-Counter

This block watches for software that has stopped servicing the system. A down-counter of CNT_W bits (15 by default) is stepped by a prescaler that divides the bus clock by one of two ratios (16 or 128 by default). The counter starts from its all-ones value, so one full period is `ratio * 2^CNT_W` bus-clock cycles. At the default ratio of 16 and a 10 MHz bus clock, that is about 52.4 ms. Software has to write the restart strobe before the counter runs past zero. If it does not, the block raises a one-cycle interrupt request and reloads itself for the next period.

After reset the block is dormant. The prescaler and the counter hold their reset values until the first restart write. A two-state machine tracks this. `ST_IDLE` moves to `ST_RUN` on the first restart strobe (transition "arm"). `ST_RUN` loops on itself for every other input (transition "hold"). Only reset returns the block to `ST_IDLE`. Once armed, software cannot stop the watchdog.

The prescaler is cleared only by reset. Restart writes and underflows leave its phase alone, so the first step after a restart can come early by up to one prescale interval. An 8-bit control register holds the ratio select in bit 7. A new ratio is taken up at the next prescaler tick.

Top module: `wdog_prescaled`

## Requirements
- R1: During and right after reset, `irq` is 0, `count` is all ones and `ctrl_rdata` is 0x00.
- R2: Until the first `start_wr`, `count` stays all ones and `irq` stays 0, even when the control register is written.
- R3: `ctrl_rdata` returns the last value written with `ctrl_wr`, with all 8 bits. Bit 7 = 0 selects the low ratio DIV_LO and bit 7 = 1 selects the high ratio DIV_HI.
- R4: `count` reads all ones after each clock edge at which `start_wr` is sampled high. The value on `bus_wdata` has no effect on a restart.
- R5: After the first `start_wr` at edge E, `count` first decrements at edge E + D, where D is the selected ratio. It then decrements by one every D edges.
- R6: `count` steps past zero at the 2^CNT_W-th prescaler tick after a load. At that edge `irq` goes high for exactly one cycle and `count` reads all ones again. The period then repeats.
- R7: A restart does not clear the prescaler. After a restart, the first decrement falls on the next tick of the prescaler's running phase.
- R8: A ratio change written while the block runs leaves the interval up to the next tick unchanged. From that tick on, the new ratio sets the spacing.
- R9: When `start_wr` is sampled at the same edge as an underflow, the restart wins: `irq` stays 0 and `count` reloads.
- R10: Once running, the block keeps counting and raising `irq` whatever is written to the control register. Only reset stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wdata | input | 8 | Write data shared by both registers |
| ctrl_wr | input | 1 | Write strobe for the control register |
| start_wr | input | 1 | Write strobe for the restart register (data ignored) |
| ctrl_rdata | output | 8 | Control register read value |
| irq | output | 1 | One-cycle watchdog interrupt request |
| count | output | CNT_W | Current counter value, read-only |

## Verification
The bench runs with a 5-bit counter and ratios of 4 and 8, so that full periods fit in a short run. The stimulus patterns are:
- A long idle stretch with control writes and no restart. This separates a dormant block from one that starts on any write.
- A first restart followed by two free-running periods. This checks the first-step delay and the underflow period.
- A restart placed off the prescaler phase. This separates a prescaler that keeps its phase from one that is cleared on restart.
- A ratio change written in the middle of a prescale interval. This shows whether the old spacing is finished before the new one applies.
- A restart landing on the underflow edge. This shows which of the two events has priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    // Width of the control register and position of the ratio select bit
    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned SEL_BIT = 7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wdog_state_e;
endpackage

// File: rtl/wdog_mode_fsm.sv
module wdog_mode_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    output logic running
);
    wdog_state_e state_q, state_d;

    // Next state: "arm" on the first restart strobe, "hold" once running
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start_wr ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: running = 1'b0;
            ST_RUN:  running = 1'b1;
        endcase
    end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned DIV_LO = 16,
    parameter int unsigned DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sel_req,
    output logic tick
);
    localparam int unsigned PRE_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
    localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(DIV_LO - 1);
    localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(DIV_HI - 1);

    logic [PRE_W-1:0] pre_q;
    logic             sel_act_q;
    logic [PRE_W-1:0] limit;

    assign limit = sel_act_q ? LIM_HI : LIM_LO;
    assign tick  = enable && (pre_q == limit);

    // The phase is cleared by reset only. The ratio is taken up on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            sel_act_q <= 1'b0;
        end else if (!enable) begin
            sel_act_q <= sel_req;
        end else if (tick) begin
            pre_q     <= '0;
            sel_act_q <= sel_req;
        end else begin
            pre_q     <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             uflow
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    // A load takes priority over a step. Stepping past zero reloads the counter and pulses uflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= FULL;
            uflow <= 1'b0;
        end else begin
            uflow <= 1'b0;
            if (load) begin
                count <= FULL;
            end else if (step) begin
                if (count == '0) begin
                    count <= FULL;
                    uflow <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W  = 15,
    parameter int unsigned DIV_LO = 16,
    parameter int unsigned DIV_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] bus_wdata,
    input  logic              ctrl_wr,
    input  logic              start_wr,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              irq,
    output logic [CNT_W-1:0]  count
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              running;
    logic              tick;

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata;
    end
    assign ctrl_rdata = ctrl_q;

    wdog_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .running  (running)
    );

    wdog_prescaler #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (running),
        .sel_req (ctrl_q[SEL_BIT]),
        .tick    (tick)
    );

    wdog_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_wr),
        .step  (tick),
        .count (count),
        .uflow (irq)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_wr,
    input logic             running,
    input logic             irq,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    // R2: a dormant block holds the full count and raises no request
    p_dormant_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (count == FULL) && !irq);

    // R2: only a restart strobe can arm the block
    p_arm_only_by_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_wr) |=> !running);

    // R4, R9: a restart reloads and suppresses the request
    p_start_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (count == FULL) && !irq);

    // R6: the request comes with a reload and lasts one cycle
    p_irq_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == FULL));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: the count only steps down by one or reloads
    p_step_or_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (count == $past(count) - CNT_W'(1)) || (count == FULL));

    // R10: once running, the block never stops
    p_no_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
endmodule

bind wdog_prescaled wdog_checker #(.CNT_W(CNT_W)) u_wdog_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .running  (running),
    .irq      (irq),
    .count    (count)
);

// File: tb/wdog_prescaled_tb_top.sv
module wdog_prescaled_tb_top;
    localparam int unsigned CNT_W  = 5;
    localparam int unsigned DIV_LO = 4;
    localparam int unsigned DIV_HI = 8;
    localparam int          TICKS  = 1 << CNT_W;
    localparam int          FULL   = TICKS - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       ctrl_wr = 1'b0;
    logic       start_wr = 1'b0;
    logic [7:0] ctrl_rdata;
    logic       irq;
    logic [CNT_W-1:0] count;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    // Bench model of the prescaler phase: ticks at tick_base + k*tick_d
    int tick_base;
    int tick_d;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_prescaled #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .ctrl_wr(ctrl_wr),
        .start_wr(start_wr), .ctrl_rdata(ctrl_rdata), .irq(irq), .count(count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic go_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int next_tick(input int after);
        int k;
        k = (after - tick_base) / tick_d + 1;
        return tick_base + k * tick_d;
    endfunction

    // Drive a write so that it is sampled at edge e
    task automatic write_ctrl_at(input int e, input logic [7:0] v);
        go_to(e - 1);
        bus_wdata = v; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic start_at(input int e, input logic [7:0] junk);
        go_to(e - 1);
        bus_wdata = junk; start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    // Monitor: every request must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                chk(irq == 1'b1, "R6 irq at expected edge", irq, 1);
                void'(exp_q.pop_front());
            end else if (irq) begin
                chk(1'b0, "R6/R9 unexpected irq", cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int es, u, u2, u3, t;
        go_to(3);
        chk(irq == 1'b0, "R1 irq in reset", irq, 0);
        chk(count == FULL, "R1 count in reset", count, FULL);
        chk(ctrl_rdata == 8'h00, "R1 ctrl in reset", ctrl_rdata, 0);
        rst_n = 1'b1;
        go_to(6);
        chk(count == FULL && irq == 1'b0, "R1 after reset", count, FULL);

        // R2: idle stretch with control writes, no restart
        write_ctrl_at(10, 8'h80);
        chk(ctrl_rdata == 8'h80, "R3 readback 0x80", ctrl_rdata, 8'h80);
        go_to(300);
        chk(count == FULL, "R2 still dormant", count, FULL);
        write_ctrl_at(302, 8'h35);
        chk(ctrl_rdata == 8'h35, "R3 readback 0x35", ctrl_rdata, 8'h35);
        go_to(310);
        chk(count == FULL, "R2 dormant after ctrl write", count, FULL);

        // First start, low ratio
        es = 320;
        tick_base = es; tick_d = DIV_LO;
        exp_q.push_back(es + TICKS * DIV_LO);
        exp_q.push_back(es + 2 * TICKS * DIV_LO);
        start_at(es, 8'hA5);
        chk(count == FULL, "R4 count full after start", count, FULL);
        go_to(es + DIV_LO - 1);
        chk(count == FULL, "R5 no step before D edges", count, FULL);
        go_to(es + DIV_LO);
        chk(count == FULL - 1, "R5 first step at D", count, FULL - 1);
        go_to(es + 2 * DIV_LO);
        chk(count == FULL - 2, "R5 second step", count, FULL - 2);
        go_to(es + TICKS * DIV_LO);
        chk(count == FULL, "R6 reload at underflow", count, FULL);
        go_to(es + 2 * TICKS * DIV_LO + 2);

        // R7: restart off the prescaler phase
        t = es + 2 * TICKS * DIV_LO + 10;
        u = next_tick(t) + (TICKS - 1) * DIV_LO;
        go_to(t - 1);
        exp_q.delete();
        exp_q.push_back(u);
        start_at(t, 8'h00);
        chk(count == FULL, "R4 reload with other data", count, FULL);
        go_to(next_tick(t) - 1);
        chk(count == FULL, "R7 before phase tick", count, FULL);
        go_to(next_tick(t));
        chk(count == FULL - 1, "R7 step on running phase", count, FULL - 1);
        go_to(u);
        chk(count == FULL, "R6 reload after restart", count, FULL);

        // R8: ratio change mid interval
        write_ctrl_at(u + 5, 8'h80);
        exp_q.delete();
        t = next_tick(u + 5);
        tick_base = t; tick_d = DIV_HI;
        u2 = t + (TICKS - 2) * DIV_HI;
        exp_q.push_back(u2);
        go_to(u + DIV_LO);
        chk(count == FULL - 1, "R8 old spacing kept", count, FULL - 1);
        go_to(t);
        chk(count == FULL - 2, "R8 tick on old phase", count, FULL - 2);
        go_to(t + DIV_HI - 1);
        chk(count == FULL - 2, "R8 new spacing no early step", count, FULL - 2);
        go_to(t + DIV_HI);
        chk(count == FULL - 3, "R8 new spacing step", count, FULL - 3);

        // R9: restart on the underflow edge
        go_to(u2 - 2);
        exp_q.delete();
        u3 = next_tick(u2) + (TICKS - 1) * DIV_HI;
        exp_q.push_back(u3);
        start_at(u2, 8'hFF);
        chk(irq == 1'b0, "R9 no irq when restart coincides", irq, 0);
        chk(count == FULL, "R9 reload on coincident edge", count, FULL);

        // R10: control write while running does not stop it
        write_ctrl_at(u2 + 3, 8'h80);
        go_to(next_tick(u2));
        chk(count == FULL - 1, "R10 keeps counting", count, FULL - 1);
        go_to(u3);
        chk(count == FULL, "R10 still raises irq", count, FULL);
        go_to(u3 + 3);
        chk(exp_q.size() == 0, "R6 all expected irq seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule